// File: doc/BRIEF.md
# Register-Immediate Integer Execute Unit

This block executes the 32-bit register-immediate arithmetic group of a small integer core. It holds a register file of 32 words with a hard-wired zero register. Each clock cycle it may accept one instruction word, marked by a valid strobe. From that word it takes the destination index, the source index, the operation selector and a 12-bit immediate. It reads the source register, combines it with the sign-extended immediate, and writes the result back at the next rising edge. In the same edge it advances the program counter by four.

The unit checks every word it is given. A word whose major opcode is not the register-immediate group is refused. So is a shift whose upper seven bits are not a supported pattern. A refused word writes no register and leaves the program counter alone, and a single-cycle illegal flag rises after the edge. Instruction fetch is outside the block. A combinational read port lets the surrounding logic observe any register.

Top module: `opimm_exec`

## Requirements
- R1: While the synchronous active-high reset is held through a clock edge, the program counter becomes 0, the illegal flag becomes 0 and every register reads 0.
- R2: Register index 0 always reads 0, and an accepted instruction whose destination field is 0 changes no register.
- R3: Fields are rd = bits [11:7], rs1 = bits [19:15], selector = bits [14:12], immediate = bits [31:20]. The immediate is sign-extended from bit 31. Selector 000 (ADDI) writes rs1 + immediate modulo 2^32.
- R4: Selector 010 (SLTI) writes 1 when rs1 < immediate as signed 32-bit values, else 0.
- R5: Selector 011 (SLTIU) writes 1 when rs1 < sign-extended immediate as unsigned values, else 0. An immediate of 1 therefore yields 1 only for rs1 = 0.
- R6: Selectors 100, 110 and 111 write rs1 XOR, OR and AND the sign-extended immediate, respectively.
- R7: Selector 001 (SLLI) shifts rs1 left by bits [24:20], filling with zeros. It is legal only when bits [31:25] are 0000000.
- R8: Selector 101 with bits [31:25] = 0000000 is a logical right shift by bits [24:20]. With 0100000 it is an arithmetic right shift that copies the sign bit. Any other bits [31:25] value is illegal.
- R9: A valid word whose bits [6:0] differ from 0010011, or any illegal shift, writes no register and leaves the program counter unchanged. The illegal flag is 1 for exactly the one cycle after the edge that took the word.
- R10: An accepted legal instruction adds 4 to the program counter at the same edge as its register write. A cycle with the valid strobe low changes nothing, and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr_word | input | 32 | Instruction word |
| obs_sel | input | 5 | Register index for the observation port |
| obs_val | output | 32 | Combinational value of register obs_sel |
| pc | output | 32 | Program counter |
| illegal_o | output | 1 | One-cycle pulse after a refused instruction |

## Verification
Random words are mostly drawn from the register-immediate group, with random fields and random shift upper bits. These are mixed with foreign opcodes and idle cycles, so that accepted, refused and skipped cycles are all told apart through the program counter and the flag. Directed words build extreme operands to show the difference between signed and unsigned compares and between arithmetic and logical right shifts: all-ones, 0x7FFFFFFF and 0x80000000. The wrap of an overflowing add is tested the same way. Writes aimed at register 0 and sweeps of the whole register file show that refused words and zero destinations leave every register untouched.

// File: rtl/opimm_exec.sv
`timescale 1ns/1ps
module opimm_exec #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic [31:0]             instr_word,
  input  logic [$clog2(NREG)-1:0] obs_sel,
  output logic [XLEN-1:0]         obs_val,
  output logic [XLEN-1:0]         pc,
  output logic                    illegal_o
);
  localparam int AW = $clog2(NREG);
  localparam logic [6:0] OP_GRP = 7'b0010011;

  logic [XLEN-1:0] regs [NREG];
  logic [XLEN-1:0] pc_q, src, imm, result;
  logic            ill_q, legal, shift_ok;

  wire [6:0]    op    = instr_word[6:0];
  wire [AW-1:0] rd    = instr_word[7 +: AW];
  wire [AW-1:0] rs1   = instr_word[15 +: AW];
  wire [2:0]    sel   = instr_word[14:12];
  wire [6:0]    upper = instr_word[31:25];
  wire [4:0]    shamt = instr_word[24:20];

  assign imm     = {{(XLEN-12){instr_word[31]}}, instr_word[31:20]};
  assign src     = (rs1 == '0) ? '0 : regs[rs1];
  assign obs_val = (obs_sel == '0) ? '0 : regs[obs_sel];
  assign pc        = pc_q;
  assign illegal_o = ill_q;

  always_comb begin
    case (sel)
      3'b001:  shift_ok = (upper == 7'b0000000);
      3'b101:  shift_ok = (upper == 7'b0000000) || (upper == 7'b0100000);
      default: shift_ok = 1'b1;
    endcase
  end
  assign legal = (op == OP_GRP) && shift_ok;

  always_comb begin
    case (sel)
      3'b000:  result = src + imm;
      3'b010:  result = {{(XLEN-1){1'b0}}, $signed(src) < $signed(imm)};
      3'b011:  result = {{(XLEN-1){1'b0}}, src < imm};
      3'b100:  result = src ^ imm;
      3'b110:  result = src | imm;
      3'b111:  result = src & imm;
      3'b001:  result = src << shamt;
      default: result = upper[5] ? XLEN'($signed(src) >>> shamt) : (src >> shamt);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pc_q  <= '0;
      ill_q <= 1'b0;
    end else begin
      ill_q <= instr_valid && !legal;
      if (instr_valid && legal) begin
        pc_q <= pc_q + XLEN'(4);
        if (rd != '0) regs[rd] <= result;
      end
    end
  end

  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_valid) && !$past(rst) && !illegal_o) |-> (pc == $past(pc) + XLEN'(4)));
  a_r9_refused_hold: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (pc == $past(pc) && $past(instr_valid)));
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(instr_valid) && !$past(rst)) |-> (pc == $past(pc) && !illegal_o));
  a_r7_slli_upper: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && op == OP_GRP && sel == 3'b001 && upper != 7'b0) |=> illegal_o);
  a_r8_sr_upper: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && op == OP_GRP && sel == 3'b101 && upper != 7'b0 && upper != 7'b0100000) |=> illegal_o);
endmodule

// File: tb/opimm_exec_tb.sv
`timescale 1ns/1ps
module opimm_exec_tb_top;
  logic        clk = 1'b0, rst = 1'b1, instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  obs_sel = '0;
  logic [31:0] obs_val, pc;
  logic        illegal_o;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] mreg [32];
  logic [31:0] mpc;

  always #4 clk = ~clk;

  opimm_exec dut_i (.clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .obs_sel(obs_sel), .obs_val(obs_val), .pc(pc), .illegal_o(illegal_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [11:0] im, input logic [4:0] s1,
                                      input logic [2:0] f, input logic [4:0] d);
    return {im, s1, f, d, 7'b0010011};
  endfunction

  function automatic logic model(input logic [31:0] w, output logic [31:0] r);
    logic [31:0] a, im;
    a  = (w[19:15] == 0) ? 32'h0 : mreg[w[19:15]];
    im = {{20{w[31]}}, w[31:20]};
    r  = '0;
    if (w[6:0] != 7'b0010011) return 1'b0;
    case (w[14:12])
      3'd0: r = a + im;
      3'd2: r = (int'(a) < int'(im)) ? 32'd1 : 32'd0;
      3'd3: r = (a < im) ? 32'd1 : 32'd0;
      3'd4: r = a ^ im;
      3'd6: r = a | im;
      3'd7: r = a & im;
      3'd1: begin if (w[31:25] != 0) return 1'b0; r = a << w[24:20]; end
      default: begin
        if (w[31:25] == 7'b0) r = a >> w[24:20];
        else if (w[31:25] == 7'b0100000) r = 32'(int'(a) >>> w[24:20]);
        else return 1'b0;
      end
    endcase
    return 1'b1;
  endfunction

  task automatic run(input logic [31:0] w, input logic v, input string req);
    logic ok; logic [31:0] r;
    ok = model(w, r);
    @(negedge clk); instr_word = w; instr_valid = v;
    @(negedge clk); instr_valid = 1'b0;
    if (v && ok) begin
      mpc += 4;
      if (w[11:7] != 0) mreg[w[11:7]] = r;
    end
    chk({req, " pc"}, pc, mpc);
    chk({req, " illegal flag"}, {31'b0, illegal_o}, {31'b0, v && !ok});
    obs_sel = w[11:7]; #1;
    chk({req, " rd value"}, obs_val, (w[11:7] == 0) ? 32'h0 : mreg[w[11:7]]);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      obs_sel = 5'(i); #1;
      chk(req, obs_val, (i == 0) ? 32'h0 : mreg[i]);
    end
  endtask

  initial begin
    #(8ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;
    instr_valid = 1'b1; instr_word = enc(12'h005, 5'd0, 3'd0, 5'd1);
    repeat (3) @(negedge clk);
    rst = 1'b0; instr_valid = 1'b0;
    chk("R1 pc after reset", pc, 32'h0);
    chk("R1 flag after reset", {31'b0, illegal_o}, 32'h0);
    sweep("R1 register cleared");

    run(enc(12'hFFF, 5'd0, 3'd0, 5'd1), 1, "R3 addi -1");
    run(enc(12'h001, 5'd1, 3'd0, 5'd2), 1, "R3 addi wrap to 0");
    run({7'b0, 5'd1, 5'd1, 3'b101, 5'd4, 7'b0010011}, 1, "R8 srli 1");
    run(enc(12'h001, 5'd4, 3'd0, 5'd5), 1, "R3 addi overflow 0x80000000");
    run(enc(12'h001, 5'd0, 3'd3, 5'd6), 1, "R5 sltiu x0,1");
    run(enc(12'h001, 5'd5, 3'd3, 5'd7), 1, "R5 sltiu nonzero,1");
    run(enc(12'hFFF, 5'd4, 3'd3, 5'd8), 1, "R5 sltiu vs all-ones");
    run(enc(12'h000, 5'd5, 3'd2, 5'd9), 1, "R4 slti negative");
    run(enc(12'hFFF, 5'd4, 3'd2, 5'd10), 1, "R4 slti max vs -1");
    run({7'b0100000, 5'd31, 5'd5, 3'b101, 5'd11, 7'b0010011}, 1, "R8 srai 31");
    run({7'b0, 5'd31, 5'd5, 3'b101, 5'd12, 7'b0010011}, 1, "R8 srli 31");
    run({7'b0, 5'd31, 5'd6, 3'b001, 5'd13, 7'b0010011}, 1, "R7 slli 31");
    run(enc(12'hFFF, 5'd4, 3'd4, 5'd14), 1, "R6 xori not");
    run(enc(12'h80F, 5'd4, 3'd6, 5'd15), 1, "R6 ori sign-ext");
    run(enc(12'h80F, 5'd1, 3'd7, 5'd16), 1, "R6 andi sign-ext");
    run(enc(12'h123, 5'd1, 3'd0, 5'd0), 1, "R2 write to x0");
    run({7'b0100000, 5'd3, 5'd4, 3'b001, 5'd17, 7'b0010011}, 1, "R7 slli bad upper");
    run({7'b0010000, 5'd3, 5'd4, 3'b101, 5'd17, 7'b0010011}, 1, "R8 shift bad upper");
    run({12'h001, 5'd1, 3'd0, 5'd17, 7'b0110011}, 1, "R9 foreign opcode");
    run(enc(12'h055, 5'd1, 3'd0, 5'd18), 0, "R10 idle cycle");
    sweep("R9 registers after refusals");

    for (int k = 0; k < 3000; k++) begin
      w = $urandom();
      if ($urandom_range(9) != 0) w[6:0] = 7'b0010011;
      if (w[13:12] == 2'b01) begin
        case ($urandom_range(3))
          0, 1: w[31:25] = 7'b0;
          2:    w[31:25] = 7'b0100000;
          default: ;
        endcase
      end
      run(w, $urandom_range(7) != 0, "R3-group random");
      if (k % 500 == 499) sweep("R2 random sweep");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule